// File: doc/BRIEF.md
# Fine-Grained Label Egress Filter

This block is the last decision stage before a decapsulated packet leaves a switch through its edge ports. It receives one classified packet per cycle: whether it carries a 24-bit fine-grained label or an ordinary 12-bit VLAN label, the label value, the four tag bits saved at ingress, and a few flags. The flags say whether the transport header was multi-destination, whether the inner destination address is a group address, which ports the destination address is known behind, and whether the packet is to be dropped.

The block also reads a per-port configuration table. Each port is either in fine-label mode or in VLAN mode. It holds a few label slots; each slot has a valid bit, a label and, for fine-label ports, the C-VLAN the label is translated to on that port. Each port also has a strip-tag option. One cycle after the packet, the block returns three things:
- a port mask of where the packet may be emitted;
- for every emitting port, the C-VLAN to write and whether the tag is stripped;
- the priority/DEI bits to restore, and whether the packet may still be relayed onward on a distribution tree.

Isolation is strict. A fine label is accepted only by a port that lists the complete 24-bit value. A port whose VLAN equals the label's high part does not qualify.

Top module: `lbl_egress_filter`

## Requirements
- R1: All outputs are registered and reflect the inputs of the previous clock edge; `out_valid` is `in_valid` delayed by one cycle, and a cycle with `in_valid` low produces an all-zero mask, C-VLANs, strip bits, tag and relay.
- R2: A packet with `in_kind`=1 (fine label) may be emitted on port p only if `cfg_fine_mode[p]`=1 and one of port p's valid slots holds a 24-bit label equal to `in_label` in all 24 bits; a VLAN-mode port whose slot VLAN equals `in_label[23:12]` never qualifies.
- R3: A packet with `in_kind`=0 (VLAN label, VLAN id in `in_label[11:0]`) may be emitted only on ports with `cfg_fine_mode[p]`=0 that have a valid slot whose bits [11:0] equal `in_label[11:0]`; its output C-VLAN on such a port is `in_label[11:0]`.
- R4: For a fine label, port p's output C-VLAN is the mapped value of the matching slot; when several slots of one port match, the lowest-numbered slot wins. Slot s of port p sits at index p*SLOTS+s of the flat configuration vectors.
- R5: `out_tag` equals the `in_tag` presented with a valid packet (bits [3:1] priority, bit 0 DEI), taken from the saved low-part tag, regardless of destination.
- R6: `out_strip[p]` is `cfg_strip[p]` for an emitting port and 0 otherwise; `out_cvlan` slice p (bits p*12 +: 12) is 0 for a non-emitting port.
- R7: When `in_mdest`=1, or `in_da_group`=1 on a unicast header, the mask is every port that holds the label.
- R8: For a known-unicast packet (`in_mdest`=0, `in_da_group`=0) the mask is the label-holding ports that are also set in `in_da_hit`; if that intersection is empty, the mask is every label-holding port.
- R9: `out_relay` is 1 only for a valid, non-discarded packet with `in_mdest`=1; a unicast-header packet, including one with a group inner address, is never relayed.
- R10: A valid packet with `in_discard`=1 yields an all-zero mask and `out_relay`=0.
- R11: Synchronous active-high reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet present this cycle |
| in_kind | input | 1 | 1 = fine label, 0 = VLAN label |
| in_label | input | 24 | Packet label (VLAN id in [11:0] for VLAN kind) |
| in_tag | input | 4 | Saved priority [3:1] and DEI [0] |
| in_mdest | input | 1 | Transport header is multi-destination |
| in_da_group | input | 1 | Inner destination is broadcast or multicast |
| in_da_hit | input | NPORTS | Ports where the inner destination is known |
| in_discard | input | 1 | Classification asked for drop |
| cfg_fine_mode | input | NPORTS | Per-port mode, 1 = fine label |
| cfg_strip | input | NPORTS | Per-port strip-tag option |
| cfg_slot_vld | input | NPORTS*SLOTS | Slot valid bits |
| cfg_slot_lbl | input | NPORTS*SLOTS*24 | Slot labels |
| cfg_slot_map | input | NPORTS*SLOTS*12 | Slot C-VLAN translation |
| out_valid | output | 1 | Result valid |
| out_mask | output | NPORTS | Permitted egress ports |
| out_cvlan | output | NPORTS*12 | Per-port C-VLAN to emit |
| out_strip | output | NPORTS | Per-port strip indication |
| out_tag | output | 4 | Restored priority/DEI |
| out_relay | output | 1 | Packet may continue on a distribution tree |

## Verification
The two functions that meet in one cycle are the unicast destination narrowing and the label isolation check. The case that matters is a known-unicast fine-label packet whose destination hit lies only on a VLAN-mode port carrying the label's high part. Isolation must reject that port, which empties the intersection and forces a flood to the label holders. A directed case builds exactly this arrangement, and random traffic over a small label pool produces many more such collisions. Every one is judged against an independently computed mask, per-port C-VLAN and strip value.

// File: rtl/lbl_egr_pkg.sv
package lbl_egr_pkg;
    localparam int LBL_W = 24;
    localparam int VID_W = 12;
    localparam int TAG_W = 4;

    typedef enum logic {
        LK_VLAN = 1'b0,
        LK_FINE = 1'b1
    } lbl_kind_e;

    typedef struct packed {
        lbl_kind_e          kind;
        logic [LBL_W-1:0]   label;
        logic [TAG_W-1:0]   tag;
        logic               mdest;
        logic               da_group;
        logic               discard;
    } pkt_s;

    typedef struct packed {
        logic               hold;
        logic [VID_W-1:0]   cvlan;
    } port_hit_s;

    function automatic logic [VID_W-1:0] vid_of(input logic [LBL_W-1:0] l);
        return l[VID_W-1:0];
    endfunction

    // Strict isolation: kinds must agree with the port mode; fine labels
    // compare all 24 bits, VLAN labels compare the 12-bit id only.
    function automatic logic slot_match(
        input lbl_kind_e        kind,
        input logic             fine_port,
        input logic             vld,
        input logic [LBL_W-1:0] slot,
        input logic [LBL_W-1:0] lbl
    );
        if (!vld)
            return 1'b0;
        if (fine_port)
            return (kind == LK_FINE) && (slot == lbl);
        return (kind == LK_VLAN) && (vid_of(slot) == vid_of(lbl));
    endfunction
endpackage

// File: rtl/lbl_port_match.sv
module lbl_port_match
    import lbl_egr_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  pkt_s                    pkt,
    input  logic                    fine_port,
    input  logic [SLOTS-1:0]        slot_vld,
    input  logic [SLOTS*LBL_W-1:0]  slot_lbl,
    input  logic [SLOTS*VID_W-1:0]  slot_map,
    output port_hit_s               hit
);
    logic [SLOTS-1:0] slot_hit;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_hit[s] = slot_match(pkt.kind, fine_port, slot_vld[s],
                                        slot_lbl[s*LBL_W +: LBL_W], pkt.label);
    end

    // Walk from the top so the lowest-numbered matching slot is applied last.
    always_comb begin
        hit      = '0;
        hit.hold = |slot_hit;
        for (int s = SLOTS-1; s >= 0; s--) begin
            if (slot_hit[s])
                hit.cvlan = fine_port ? slot_map[s*VID_W +: VID_W] : vid_of(pkt.label);
        end
    end
endmodule

// File: rtl/lbl_dest_select.sv
module lbl_dest_select
    import lbl_egr_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  pkt_s                pkt,
    input  logic [NPORTS-1:0]   label_mask,
    input  logic [NPORTS-1:0]   da_hit,
    output logic [NPORTS-1:0]   mask,
    output logic                relay
);
    logic [NPORTS-1:0] known;
    logic              unicast_known;

    assign known         = label_mask & da_hit;
    assign unicast_known = !pkt.mdest && !pkt.da_group;

    always_comb begin
        mask  = label_mask;
        relay = pkt.mdest;
        if (unicast_known && (known != '0))
            mask = known;
        if (pkt.discard) begin
            mask  = '0;
            relay = 1'b0;
        end
    end
endmodule

// File: rtl/lbl_egress_filter.sv
module lbl_egress_filter
    import lbl_egr_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int SLOTS  = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic                            in_kind,
    input  logic [23:0]                     in_label,
    input  logic [3:0]                      in_tag,
    input  logic                            in_mdest,
    input  logic                            in_da_group,
    input  logic [NPORTS-1:0]               in_da_hit,
    input  logic                            in_discard,
    input  logic [NPORTS-1:0]               cfg_fine_mode,
    input  logic [NPORTS-1:0]               cfg_strip,
    input  logic [NPORTS*SLOTS-1:0]         cfg_slot_vld,
    input  logic [NPORTS*SLOTS*24-1:0]      cfg_slot_lbl,
    input  logic [NPORTS*SLOTS*12-1:0]      cfg_slot_map,
    output logic                            out_valid,
    output logic [NPORTS-1:0]               out_mask,
    output logic [NPORTS*12-1:0]            out_cvlan,
    output logic [NPORTS-1:0]               out_strip,
    output logic [3:0]                      out_tag,
    output logic                            out_relay
);
    localparam int PORT_LBL_W = SLOTS * LBL_W;
    localparam int PORT_MAP_W = SLOTS * VID_W;

    pkt_s              pkt;
    port_hit_s         hits [NPORTS];
    logic [NPORTS-1:0] label_mask;
    logic [NPORTS-1:0] sel_mask;
    logic              sel_relay;

    assign pkt.kind     = lbl_kind_e'(in_kind);
    assign pkt.label    = in_label;
    assign pkt.tag      = in_tag;
    assign pkt.mdest    = in_mdest;
    assign pkt.da_group = in_da_group;
    assign pkt.discard  = in_discard;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        lbl_port_match #(.SLOTS(SLOTS)) match_i (
            .pkt       (pkt),
            .fine_port (cfg_fine_mode[p]),
            .slot_vld  (cfg_slot_vld[p*SLOTS +: SLOTS]),
            .slot_lbl  (cfg_slot_lbl[p*PORT_LBL_W +: PORT_LBL_W]),
            .slot_map  (cfg_slot_map[p*PORT_MAP_W +: PORT_MAP_W]),
            .hit       (hits[p])
        );
        assign label_mask[p] = hits[p].hold;
    end

    lbl_dest_select #(.NPORTS(NPORTS)) sel_i (
        .pkt        (pkt),
        .label_mask (label_mask),
        .da_hit     (in_da_hit),
        .mask       (sel_mask),
        .relay      (sel_relay)
    );

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_cvlan <= '0;
            out_strip <= '0;
            out_tag   <= '0;
            out_relay <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            out_mask  <= sel_mask;
            out_tag   <= in_tag;
            out_relay <= sel_relay;
            for (int p = 0; p < NPORTS; p++) begin
                out_cvlan[p*VID_W +: VID_W] <= sel_mask[p] ? hits[p].cvlan : '0;
                out_strip[p]                <= sel_mask[p] & cfg_strip[p];
            end
        end
    end
endmodule

// File: rtl/lbl_egress_chk.sv
module lbl_egress_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_kind,
    input logic [3:0]        in_tag,
    input logic              in_mdest,
    input logic              in_discard,
    input logic [NPORTS-1:0] cfg_fine_mode,
    input logic              out_valid,
    input logic [NPORTS-1:0] out_mask,
    input logic [NPORTS-1:0] out_strip,
    input logic [3:0]        out_tag,
    input logic              out_relay
);
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_mask == '0 && !out_relay));
    p_fine_isolation_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind) |=> ((out_mask & ~$past(cfg_fine_mode)) == '0));
    p_vlan_isolation_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_kind) |=> ((out_mask & $past(cfg_fine_mode)) == '0));
    p_tag_restore_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_tag == $past(in_tag)));
    p_strip_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (out_strip & ~out_mask) == '0);
    p_relay_unicast_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mdest) |=> !out_relay);
    p_discard_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_discard) |=> (out_mask == '0 && !out_relay));
endmodule

bind lbl_egress_filter lbl_egress_chk #(.NPORTS(NPORTS)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_kind       (in_kind),
    .in_tag        (in_tag),
    .in_mdest      (in_mdest),
    .in_discard    (in_discard),
    .cfg_fine_mode (cfg_fine_mode),
    .out_valid     (out_valid),
    .out_mask      (out_mask),
    .out_strip     (out_strip),
    .out_tag       (out_tag),
    .out_relay     (out_relay)
);

// File: tb/lbl_egress_filter_tb_top.sv
module lbl_egress_filter_tb_top;
    localparam int CLK_NS = 10;
    localparam int N = 4;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_kind = 1'b0, in_mdest = 1'b0, in_da_group = 1'b0, in_discard = 1'b0;
    logic [23:0] in_label = '0;
    logic [3:0]  in_tag = '0;
    logic [N-1:0] in_da_hit = '0;
    logic [N-1:0] cfg_fine_mode, cfg_strip;
    logic [N*S-1:0] cfg_slot_vld;
    logic [N*S*24-1:0] cfg_slot_lbl;
    logic [N*S*12-1:0] cfg_slot_map;
    logic out_valid, out_relay;
    logic [N-1:0] out_mask, out_strip;
    logic [N*12-1:0] out_cvlan;
    logic [3:0] out_tag;

    logic        b_fine [N];
    logic        b_strip[N];
    logic        b_vld  [N][S];
    logic [23:0] b_lbl  [N][S];
    logic [11:0] b_map  [N][S];

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    always_comb begin
        cfg_fine_mode = '0; cfg_strip = '0; cfg_slot_vld = '0;
        cfg_slot_lbl = '0; cfg_slot_map = '0;
        for (int p = 0; p < N; p++) begin
            cfg_fine_mode[p] = b_fine[p];
            cfg_strip[p]     = b_strip[p];
            for (int s = 0; s < S; s++) begin
                cfg_slot_vld[p*S+s]            = b_vld[p][s];
                cfg_slot_lbl[(p*S+s)*24 +: 24] = b_lbl[p][s];
                cfg_slot_map[(p*S+s)*12 +: 12] = b_map[p][s];
            end
        end
    end

    lbl_egress_filter #(.NPORTS(N), .SLOTS(S)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_label(in_label), .in_tag(in_tag), .in_mdest(in_mdest),
        .in_da_group(in_da_group), .in_da_hit(in_da_hit), .in_discard(in_discard),
        .cfg_fine_mode(cfg_fine_mode), .cfg_strip(cfg_strip),
        .cfg_slot_vld(cfg_slot_vld), .cfg_slot_lbl(cfg_slot_lbl),
        .cfg_slot_map(cfg_slot_map), .out_valid(out_valid), .out_mask(out_mask),
        .out_cvlan(out_cvlan), .out_strip(out_strip), .out_tag(out_tag),
        .out_relay(out_relay)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Expected results from the requirements.
    logic [N-1:0]    e_mask, e_strip;
    logic [N*12-1:0] e_cvlan;
    logic            e_relay;

    task automatic build_expect();
        logic [N-1:0] holders, known;
        logic [11:0]  cv [N];
        holders = '0;
        for (int p = 0; p < N; p++) begin
            cv[p] = '0;
            for (int s = S-1; s >= 0; s--) begin
                logic m;
                if (b_fine[p]) m = b_vld[p][s] && in_kind && (b_lbl[p][s] == in_label);
                else           m = b_vld[p][s] && !in_kind && (b_lbl[p][s][11:0] == in_label[11:0]);
                if (m) begin
                    holders[p] = 1'b1;
                    cv[p] = b_fine[p] ? b_map[p][s] : in_label[11:0];
                end
            end
        end
        known = holders & in_da_hit;
        e_mask = holders;
        if (!in_mdest && !in_da_group && known != '0) e_mask = known;
        e_relay = in_mdest;
        if (in_discard) begin e_mask = '0; e_relay = 1'b0; end
        e_cvlan = '0; e_strip = '0;
        for (int p = 0; p < N; p++) begin
            if (e_mask[p]) begin
                e_cvlan[p*12 +: 12] = cv[p];
                e_strip[p] = b_strip[p];
            end
        end
    endtask

    // Called at a falling edge; result checked at the next falling edge.
    task automatic send(input logic kind, input logic [23:0] lbl, input logic [3:0] tg,
                        input logic md, input logic grp, input logic [N-1:0] hit, input logic dis);
        string mtag, ctag;
        in_valid = 1'b1; in_kind = kind; in_label = lbl; in_tag = tg;
        in_mdest = md; in_da_group = grp; in_da_hit = hit; in_discard = dis;
        build_expect();
        if (dis)             mtag = "R10";
        else if (!kind)      mtag = "R3";
        else if (md || grp)  mtag = "R7/R2";
        else                 mtag = "R8/R2";
        ctag = kind ? "R4" : "R3";
        @(negedge clk);
        chk("R1", "valid", 64'(out_valid), 64'(1));
        chk(mtag, "mask", 64'(out_mask), 64'(e_mask));
        chk(ctag, "cvlan", 64'(out_cvlan), 64'(e_cvlan));
        chk("R6", "strip", 64'(out_strip), 64'(e_strip));
        chk("R5", "tag", 64'(out_tag), 64'(tg));
        chk("R9", "relay", 64'(out_relay), 64'(e_relay));
    endtask

    task automatic idle_check();
        in_valid = 1'b0; in_mdest = 1'b1; in_kind = 1'b1;
        @(negedge clk);
        chk("R1", "idle valid", 64'(out_valid), 64'(0));
        chk("R1", "idle mask", 64'(out_mask), 64'(0));
        chk("R1", "idle relay", 64'(out_relay), 64'(0));
        chk("R1", "idle tag", 64'(out_tag), 64'(0));
    endtask

    task automatic clear_cfg();
        for (int p = 0; p < N; p++) begin
            b_fine[p] = 1'b0; b_strip[p] = 1'b0;
            for (int s = 0; s < S; s++) begin
                b_vld[p][s] = 1'b0; b_lbl[p][s] = '0; b_map[p][s] = '0;
            end
        end
    endtask

    localparam logic [23:0] LX = 24'h155_2A3;

    function automatic logic [23:0] pool(input int k);
        case (k % 4)
            0: return LX;
            1: return 24'h155_2A4;
            2: return 24'h2A3_155;
            default: return 24'h000_155;
        endcase
    endfunction

    initial begin
        clear_cfg();
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk("R11", "reset mask", 64'(out_mask), 64'(0));
        chk("R11", "reset valid", 64'(out_valid), 64'(0));
        chk("R11", "reset cvlan", 64'(out_cvlan), 64'(0));
        rst = 1'b0;
        @(negedge clk);

        // Directed configuration
        b_fine[0] = 1; b_vld[0][0] = 1; b_lbl[0][0] = LX; b_map[0][0] = 12'h010;
                       b_vld[0][1] = 1; b_lbl[0][1] = LX; b_map[0][1] = 12'h020;
        b_fine[1] = 0; b_vld[1][0] = 1; b_lbl[1][0] = 24'h000_155; b_strip[1] = 1;
        b_fine[2] = 1; b_vld[2][2] = 1; b_lbl[2][2] = LX; b_map[2][2] = 12'h030; b_strip[2] = 1;
        b_fine[3] = 1; b_vld[3][0] = 1; b_lbl[3][0] = 24'h155_2A4; b_map[3][0] = 12'h040;

        // R7/R4: multi-destination flood, lowest slot on port 0
        send(1, LX, 4'hA, 1, 0, 4'b0000, 0);
        chk("R4", "port0 lowest slot", 64'(out_cvlan[11:0]), 64'(12'h010));
        chk("R2", "no VLAN-X port", 64'(out_mask[1]), 64'(0));
        // R8/R2: unicast hit only on VLAN port carrying high part -> flood
        send(1, LX, 4'h3, 0, 0, 4'b0010, 0);
        chk("R8", "fallback flood", 64'(out_mask), 64'(4'b0101));
        // R8: narrowed unicast
        send(1, LX, 4'h5, 0, 0, 4'b0100, 0);
        chk("R8", "narrowed", 64'(out_mask), 64'(4'b0100));
        // R9: unicast header with group DA: flood, no relay
        send(1, LX, 4'h7, 0, 1, 4'b0100, 0);
        chk("R9", "group unicast relay", 64'(out_relay), 64'(0));
        // R3: VLAN packet
        send(0, 24'h000_155, 4'hE, 1, 0, 4'b0000, 0);
        chk("R3", "vlan mask", 64'(out_mask), 64'(4'b0010));
        // R10: discard
        send(1, LX, 4'h1, 1, 0, 4'b1111, 1);
        idle_check();

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            if (i % 25 == 0) begin
                for (int p = 0; p < N; p++) begin
                    b_fine[p]  = 1'($urandom);
                    b_strip[p] = 1'($urandom);
                    for (int s = 0; s < S; s++) begin
                        b_vld[p][s] = 1'($urandom);
                        b_lbl[p][s] = pool(int'($urandom_range(0, 3)));
                        b_map[p][s] = 12'($urandom);
                    end
                end
            end
            send(1'($urandom), pool(int'($urandom_range(0, 3))), 4'($urandom),
                 1'($urandom), ($urandom_range(0, 3) == 0), 4'($urandom),
                 ($urandom_range(0, 7) == 0));
            if (i % 50 == 49) idle_check();
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule